// File: doc/BRIEF.md
# Condition Flag Store and Evaluator

This block keeps the four arithmetic flags of an 8-bit processor (carry, zero, sign, overflow) in a small register and answers condition queries against them. An instruction that compares, tests or computes presents fresh flag values along with a write request. Only then does the stored set change, so a compare can be issued once and any number of later instructions can query its outcome.

A query is a 4-bit condition code. The block returns one bit saying whether the condition holds. The same bit qualifies two consumers: a conditional register move, which writes its destination only when the bit is true, and a conditional relative jump, which is taken only when the bit is true. Signed orderings are derived from the sign and overflow flags together. A second, alternate flag bank can be exchanged with the active one in a single cycle.

The condition result is purely combinational from the stored flags and the code. A code presented in a cycle is answered in that same cycle.

Top module: `cond_eval`

## Requirements
- R1: On reset the active and alternate flag banks both clear to zero. The `flags` output packs the active bank as bit 3 carry (C), bit 2 zero (Z), bit 1 sign (S), bit 0 overflow (V); `next_flags` uses the same packing.
- R2: When `flag_we` is high and `swap_en` is low, the active bank loads `next_flags` at the clock edge. With both low, the active bank keeps its value whatever `next_flags` carries.
- R3: When `swap_en` is high, the active and alternate banks exchange contents at the clock edge and `flag_we` is ignored for that cycle.
- R4: Code 0000 is always true; code 0001 is never true.
- R5: Code 0010 is true when Z is set (equal); code 0011 is true when Z is clear (not equal).
- R6: Code 0100 (unsigned lower) is true when C is clear; code 0101 (unsigned higher or same) is true when C is set; code 1110 is true when C is set; code 1111 is true when C is clear.
- R7: Code 0110 (signed less) is true when S differs from V; 0111 (signed greater or equal) is its complement; 1000 (signed less or equal) is true when Z is set or S differs from V; 1001 (signed greater) is its complement.
- R8: Code 1010 is true when S is set, 1011 when S is clear, 1100 when V is set, 1101 when V is clear.
- R9: `cond_true` follows the stored flags and `cond_code` in the same cycle; a flag write becomes visible to the evaluation only after its clock edge.
- R10: `mov_we` is high only when `mov_req` is high and the condition holds; otherwise the move's destination is left unwritten.
- R11: `jmp_take` is high only when `jmp_req` is high and the condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_we | input | 1 | Load `next_flags` into the active bank |
| swap_en | input | 1 | Exchange active and alternate banks |
| next_flags | input | 4 | Candidate flags {C,Z,S,V} |
| cond_code | input | 4 | Condition selector |
| mov_req | input | 1 | A conditional move is executing |
| jmp_req | input | 1 | A conditional jump is executing |
| flags | output | 4 | Active bank {C,Z,S,V} |
| cond_true | output | 1 | Selected condition holds |
| mov_we | output | 1 | Destination write enable for the move |
| jmp_take | output | 1 | Jump is taken |

## Verification
The assertions assume the control inputs are known at every clock edge after reset and that the flag-write checks only apply when a swap is not requested in the same cycle. They also treat the move and jump requests as independent of each other, so both may be high at once. The stimulus changes every input only on the falling edge. It sweeps all sixteen flag combinations against all sixteen codes with both requests toggled, and it mixes writes, held cycles carrying garbage on `next_flags`, and swaps with a write requested alongside.

// File: rtl/cond_eval.sv
module cond_eval (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flag_we,
  input  logic       swap_en,
  input  logic [3:0] next_flags,
  input  logic [3:0] cond_code,
  input  logic       mov_req,
  input  logic       jmp_req,
  output logic [3:0] flags,
  output logic       cond_true,
  output logic       mov_we,
  output logic       jmp_take
);

  logic [3:0] act_q, alt_q;
  logic       fc, fz, fs, fv, slt, base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      alt_q <= '0;
    end else if (swap_en) begin
      act_q <= alt_q;
      alt_q <= act_q;
    end else if (flag_we) begin
      act_q <= next_flags;
    end
  end

  assign {fc, fz, fs, fv} = act_q;
  assign slt = fs ^ fv;

  always_comb begin
    case (cond_code[3:1])
      3'd0:    base = 1'b1;
      3'd1:    base = fz;
      3'd2:    base = ~fc;
      3'd3:    base = slt;
      3'd4:    base = fz | slt;
      3'd5:    base = fs;
      3'd6:    base = fv;
      default: base = fc;
    endcase
  end

  assign cond_true = base ^ cond_code[0];
  assign flags     = act_q;
  assign mov_we    = mov_req & cond_true;
  assign jmp_take  = jmp_req & cond_true;

endmodule

module cond_eval_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flag_we,
  input logic       swap_en,
  input logic [3:0] next_flags,
  input logic [3:0] cond_code,
  input logic       mov_req,
  input logic       jmp_req,
  input logic [3:0] flags,
  input logic       cond_true,
  input logic       mov_we,
  input logic       jmp_take
);

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> flags == 4'b0000); // R1
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_we && !swap_en) |=> $stable(flags)); // R2
  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !swap_en) |=> flags == $past(next_flags)); // R2
  AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cond_code == 4'b0000 |-> cond_true); // R4
  AST_NEVER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cond_code == 4'b0001 |-> !cond_true); // R4
  AST_EQ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cond_code == 4'b0010 |-> cond_true == flags[2]); // R5
  AST_SIGNED_LESS: assert property (@(posedge clk) disable iff (!rst_n)
    cond_code == 4'b0110 |-> cond_true == (flags[1] != flags[0])); // R7
  AST_MOVE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    mov_we |-> (mov_req && cond_true)); // R10
  AST_JUMP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_take |-> (jmp_req && cond_true)); // R11

endmodule

bind cond_eval cond_eval_chk u_chk (.*);

// File: tb/cond_eval_bench.sv
module cond_eval_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flag_we = 1'b0, swap_en = 1'b0, mov_req = 1'b0, jmp_req = 1'b0;
  logic [3:0] next_flags = '0, cond_code = '0;
  logic [3:0] flags;
  logic       cond_true, mov_we, jmp_take;

  always #10 clk = ~clk;

  cond_eval u_cond_eval (.*);

  typedef struct {
    logic [3:0] fl;
    logic       c, m, j;
    string      tag;
  } item_t;

  item_t      sbq[$];
  int         checks = 0, errors = 0;
  logic [3:0] m_act = '0, m_alt = '0;
  bit         done = 1'b0;

  function automatic logic eval(input logic [3:0] f, input logic [3:0] cc);
    logic c, z, s, v, r;
    {c, z, s, v} = f;
    case (cc)
      4'b0000: r = 1'b1;            4'b0001: r = 1'b0;
      4'b0010: r = z;               4'b0011: r = !z;
      4'b0100: r = !c;              4'b0101: r = c;
      4'b0110: r = s != v;          4'b0111: r = s == v;
      4'b1000: r = z || (s != v);   4'b1001: r = !z && (s == v);
      4'b1010: r = s;               4'b1011: r = !s;
      4'b1100: r = v;               4'b1101: r = !v;
      4'b1110: r = c;               default: r = !c;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [3:0] cc);
    case (cc)
      4'b0000, 4'b0001:                   return "R4";
      4'b0010, 4'b0011:                   return "R5";
      4'b0100, 4'b0101, 4'b1110, 4'b1111: return "R6";
      4'b0110, 4'b0111, 4'b1000, 4'b1001: return "R7";
      default:                            return "R8";
    endcase
  endfunction

  function automatic void chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endfunction

  task automatic step(input logic we, input logic sw, input logic [3:0] nf,
                      input logic [3:0] cc, input logic mr, input logic jr, input string tag);
    item_t it;
    @(negedge clk);
    flag_we = we; swap_en = sw; next_flags = nf; cond_code = cc; mov_req = mr; jmp_req = jr;
    it.fl = m_act;
    it.c = eval(m_act, cc);
    it.m = mr & it.c;
    it.j = jr & it.c;
    it.tag = tag;
    sbq.push_back(it);
    @(posedge clk);
    if (sw) begin
      logic [3:0] t;
      t = m_act; m_act = m_alt; m_alt = t;
    end else if (we) m_act = nf;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #5;
      while (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        chk(it.tag, "flags", flags, it.fl);
        chk(it.tag, "cond_true", cond_true, it.c);
        chk("R10", "mov_we", mov_we, it.m);
        chk("R11", "jmp_take", jmp_take, it.j);
      end
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    #5;
    chk("R1", "reset flags", flags, 4'h0);
    chk("R4", "reset cond code 0000", cond_true, 1'b1);
    rst_n = 1'b1;

    // full sweep: every flag value against every code (R4..R8, R9)
    for (int f = 0; f < 16; f++) begin
      step(1'b1, 1'b0, 4'(f), 4'b0001, 1'b0, 1'b0, "R2");
      for (int cc = 0; cc < 16; cc++)
        step(1'b0, 1'b0, 4'(~f), 4'(cc), 1'(cc & 1), 1'(f & 1), tag_of(4'(cc)));
    end

    // R9: write and query in the same cycle sees old flags, next cycle new
    step(1'b1, 1'b0, 4'b0100, 4'b0010, 1'b1, 1'b1, "R9");
    step(1'b0, 1'b0, 4'b0000, 4'b0010, 1'b1, 1'b1, "R9");

    // R2: held cycles with garbage on next_flags
    step(1'b0, 1'b0, 4'b1011, 4'b0011, 1'b0, 1'b0, "R2");
    step(1'b0, 1'b0, 4'b1111, 4'b0110, 1'b1, 1'b0, "R2");

    // R3: swaps, and swap with write requested
    step(1'b0, 1'b1, 4'b0000, 4'b0000, 1'b0, 1'b0, "R3");
    step(1'b1, 1'b0, 4'b1001, 4'b1110, 1'b0, 1'b0, "R3");
    step(1'b1, 1'b1, 4'b0110, 4'b1100, 1'b0, 1'b1, "R3");
    step(1'b0, 1'b0, 4'b0000, 4'b0100, 1'b1, 1'b0, "R3");
    step(1'b1, 1'b1, 4'b1111, 4'b1100, 1'b1, 1'b1, "R3");
    step(1'b0, 1'b0, 4'b0000, 4'b1110, 1'b1, 1'b1, "R3");

    @(negedge clk);
    #8;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule